// File: doc/BRIEF.md
# Configurable Asynchronous Character Framer

This block turns parallel bytes into asynchronous serial characters and back again. A five-bit format input selects the shape of each character: word length from 5 to 8 bits, a short or long stop period, and an optional even or odd parity bit. The transmitter waits in idle with the line high. It accepts a byte through a valid/ready handshake and then shifts out a low start bit, the data bits least significant first, the optional parity bit and the stop period. When the stop period ends it returns to idle.

The receiver runs from the same oversampling tick, which pulses for one clock sixteen times per bit period. It confirms a start bit at the middle of that bit and samples every later bit at its centre. It assembles a character of the programmed length. When it reaches the first stop bit it gives a one-cycle result with framing, parity and break flags. It does not sample any stop time after the first stop bit, so it is ready for the next start edge straight away. The baud divisor, FIFOs and interrupt logic are outside the block. The transmitter stores the format when it accepts a byte, and the receiver stores it when it confirms a start bit.

Top module: `async_char_framer`

## Requirements
- R1: fmt_i[1:0] selects the word length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits). Each transmitted character is a low start bit of 16 ticks, then that many data bits of 16 ticks each, least significant bit first.
- R2: With fmt_i[2] = 0 the line is driven high for exactly 16 ticks of stop time. tx_ready_o rises in the cycle after the tick that ends the stop time.
- R3: With fmt_i[2] = 1 the stop time is 24 ticks for a 5-bit word and 32 ticks for 6, 7 or 8-bit words.
- R4: With fmt_i[3] = 1 a parity bit of 16 ticks follows the data. fmt_i[4] = 1 selects even parity (the bit equals the XOR of the data bits) and 0 selects odd parity (its inverse).
- R5: tx_ready_o is high only while the transmitter is idle, and the line is high whenever it is. A byte is taken when tx_valid_i and tx_ready_o are both high at a clock edge. From the next cycle tx_ready_o is low and the line is low (start bit).
- R6: The receiver confirms a start bit only if the synchronised line is still low on the 8th tick after the tick that saw it fall. A low pulse shorter than that produces no result.
- R7: rx_valid_o pulses for exactly one cycle per character, 8 to 11 ticks into the first stop bit as timed from the transmitter's start. rx_data_o holds the received bits at their positions, and the bits above the word length are 0.
- R8: Only the first stop bit is sampled. A low level during any later stop time does not set rx_frame_err_o.
- R9: rx_frame_err_o is set with the result when the first stop bit is sampled low.
- R10: rx_break_o is set when the start bit, every data bit, the parity bit (if enabled) and the first stop bit are all sampled low. A break always comes with rx_frame_err_o.
- R11: rx_parity_err_o is set when parity is enabled and the received parity bit does not match the rule of R4 for the received data. It is always 0 with parity disabled.
- R12: During and right after reset, tx_ready_o = 1, txd_o = 1 and rx_valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 5 | Character format: [1:0] length, [2] long stop, [3] parity enable, [4] even parity |
| tick16_i | input | 1 | One-cycle oversampling tick, 16 per bit period |
| tx_valid_i | input | 1 | Byte offered for transmission |
| tx_data_i | input | 8 | Byte to transmit (bits above the word length ignored) |
| tx_ready_o | output | 1 | Transmitter idle and able to accept |
| txd_o | output | 1 | Serial output, idles high |
| rxd_i | input | 1 | Serial input, asynchronous |
| rx_valid_o | output | 1 | One-cycle pulse, received character ready |
| rx_data_o | output | 8 | Received character, upper bits zero |
| rx_frame_err_o | output | 1 | First stop bit sampled low |
| rx_parity_err_o | output | 1 | Parity mismatch |
| rx_break_o | output | 1 | Whole character sampled low |

## Verification
The bench keeps its own count of oversampling ticks and takes the transmitter's start as the tick count in the cycle after the handshake. It samples each transmitted bit 8 ticks into its 16-tick window. It checks tx_ready_o one tick before and exactly at the tick count where the stop time should end. The receiver's result comes from a two-flop synchroniser, a start detection one or two ticks late, an 8-tick confirmation and 16-tick bit windows. For that reason the bench records the tick count at the rx_valid_o pulse and accepts 8 to 11 ticks into the first stop bit. For the directly driven frames (framing error, break, parity error, glitch) the bench reads the captured result as soon as the first stop bit has been sent, so nothing received later can overwrite it.

// File: rtl/framer_pkg.sv
`timescale 1ns/1ps
package framer_pkg;

  localparam int FRM_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } frm_state_e;

  // field order matches the fmt_i bit positions
  typedef struct packed {
    logic       par_even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] len_sel;
  } frm_fmt_t;

  // index of the last data bit for a length selector
  function automatic logic [2:0] last_idx(input logic [1:0] sel);
    return 3'd4 + {1'b0, sel};
  endfunction

  // mask of the data bits in use
  function automatic logic [FRM_DW-1:0] len_mask(input logic [1:0] sel);
    return 8'hFF >> (2'd3 - sel);
  endfunction

  // stop time in ticks
  function automatic int stop_len(input frm_fmt_t f, input int osr);
    if (!f.long_stop) return osr;
    if (f.len_sel == 2'b00) return osr + osr / 2;
    return 2 * osr;
  endfunction

  // parity bit for the used data bits
  function automatic logic par_calc(input logic [FRM_DW-1:0] d,
                                    input logic [1:0] sel,
                                    input logic even);
    logic [FRM_DW-1:0] m;
    m = d & len_mask(sel);
    return even ? (^m) : ~(^m);
  endfunction

endpackage

// File: rtl/framer_tx.sv
`timescale 1ns/1ps
module framer_tx
  import framer_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  frm_fmt_t          fmt_i,
  input  logic              valid_i,
  input  logic [FRM_DW-1:0] data_i,
  output logic              ready_o,
  output logic              txd_o
);

  localparam int CW = $clog2(2 * OSR + 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

  frm_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        idx_q;
  logic [FRM_DW-1:0] sh_q;
  frm_fmt_t          fmt_q;
  logic              par_q;

  // named internal events
  logic [CW-1:0] lim_last;
  logic          accept;
  logic          bit_end;
  logic          data_last;

  always_comb begin
    lim_last = (state_q == ST_STOP) ? CW'(stop_len(fmt_q, OSR) - 1) : BIT_LAST;
  end

  assign accept    = valid_i && (state_q == ST_IDLE);
  assign bit_end   = tick_i && (state_q != ST_IDLE) && (cnt_q == lim_last);
  assign data_last = (idx_q == last_idx(fmt_q.len_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      fmt_q   <= '0;
      par_q   <= 1'b0;
    end else if (accept) begin
      sh_q    <= data_i;
      fmt_q   <= fmt_i;
      par_q   <= par_calc(data_i, fmt_i.len_sel, fmt_i.par_even);
      state_q <= ST_START;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (tick_i && state_q != ST_IDLE) begin
      if (bit_end) begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            sh_q <= {1'b0, sh_q[FRM_DW-1:1]};
            if (data_last) state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else           idx_q   <= idx_q + 3'd1;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign ready_o = (state_q == ST_IDLE);

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> (!ready_o && !txd_o)); // R5
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> txd_o); // R5
  AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (cnt_q <= lim_last)); // R3
  AST_TX_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !accept && $past(!ready_o)) |-> $stable(fmt_q)); // R2

endmodule

// File: rtl/framer_rx.sv
`timescale 1ns/1ps
module framer_rx
  import framer_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  frm_fmt_t          fmt_i,
  input  logic              rxd_i,
  output logic              valid_o,
  output logic [FRM_DW-1:0] data_o,
  output logic              frame_err_o,
  output logic              par_err_o,
  output logic              break_o
);

  localparam int CW = $clog2(2 * OSR + 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);

  logic              meta_q, line_q;
  frm_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        idx_q;
  logic [FRM_DW-1:0] acc_q;
  logic [1:0]        len_q;
  logic              pen_q, peven_q;
  logic              pbit_q;
  logic              low_q;

  // named internal events
  logic start_seen;
  logic start_chk;
  logic sample_stb;
  logic data_last;

  assign start_seen = tick_i && (state_q == ST_IDLE) && !line_q;
  assign start_chk  = tick_i && (state_q == ST_START) && (cnt_q == HALF_LAST);
  assign sample_stb = tick_i && (state_q inside {ST_DATA, ST_PAR, ST_STOP}) &&
                      (cnt_q == BIT_LAST);
  assign data_last  = (idx_q == last_idx(len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      line_q <= 1'b1;
    end else begin
      meta_q <= rxd_i;
      line_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      acc_q       <= '0;
      len_q       <= '0;
      pen_q       <= 1'b0;
      peven_q     <= 1'b0;
      pbit_q      <= 1'b0;
      low_q       <= 1'b0;
      valid_o     <= 1'b0;
      data_o      <= '0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
      break_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_seen) begin
        state_q <= ST_START;
        cnt_q   <= '0;
      end else if (start_chk) begin
        if (!line_q) begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
          idx_q   <= '0;
          acc_q   <= '0;
          low_q   <= 1'b1;
          len_q   <= fmt_i.len_sel;
          pen_q   <= fmt_i.par_en;
          peven_q <= fmt_i.par_even;
        end else begin
          state_q <= ST_IDLE;
        end
      end else if (sample_stb) begin
        cnt_q <= '0;
        unique case (state_q)
          ST_DATA: begin
            acc_q[idx_q] <= line_q;
            low_q        <= low_q && !line_q;
            if (data_last) state_q <= pen_q ? ST_PAR : ST_STOP;
            else           idx_q   <= idx_q + 3'd1;
          end
          ST_PAR: begin
            pbit_q  <= line_q;
            low_q   <= low_q && !line_q;
            state_q <= ST_STOP;
          end
          default: begin
            valid_o     <= 1'b1;
            data_o      <= acc_q;
            frame_err_o <= !line_q;
            break_o     <= low_q && !line_q;
            par_err_o   <= pen_q && (pbit_q != par_calc(acc_q, len_q, peven_q));
            state_q     <= ST_IDLE;
          end
        endcase
      end else if (tick_i && state_q != ST_IDLE) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((data_o & ~len_mask(len_q)) == '0)); // R7
  AST_RX_BREAK_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && break_o) |-> frame_err_o); // R10
  AST_RX_NO_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pen_q) |-> !par_err_o); // R11
  AST_RX_START_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_START && state_q == ST_DATA) |-> $past(!line_q)); // R6

endmodule

// File: rtl/async_char_framer.sv
`timescale 1ns/1ps
module async_char_framer
  import framer_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        fmt_i,
  input  logic              tick16_i,
  input  logic              tx_valid_i,
  input  logic [FRM_DW-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rx_valid_o,
  output logic [FRM_DW-1:0] rx_data_o,
  output logic              rx_frame_err_o,
  output logic              rx_parity_err_o,
  output logic              rx_break_o
);

  frm_fmt_t fmt_w;
  assign fmt_w = frm_fmt_t'(fmt_i);

  framer_tx #(.OSR(OSR)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick16_i),
    .fmt_i   (fmt_w),
    .valid_i (tx_valid_i),
    .data_i  (tx_data_i),
    .ready_o (tx_ready_o),
    .txd_o   (txd_o)
  );

  framer_rx #(.OSR(OSR)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick16_i),
    .fmt_i       (fmt_w),
    .rxd_i       (rxd_i),
    .valid_o     (rx_valid_o),
    .data_o      (rx_data_o),
    .frame_err_o (rx_frame_err_o),
    .par_err_o   (rx_parity_err_o),
    .break_o     (rx_break_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (tx_ready_o && txd_o && !rx_valid_o)); // R12

endmodule

// File: tb/async_char_framer_tb.sv
`timescale 1ns/1ps
module async_char_framer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fmt = '0;
  logic       tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       loop_en = 1'b0;
  logic       raw_rxd = 1'b1;
  wire        tx_ready, txd, rx_valid, fe, pe, brk;
  wire  [7:0] rx_data;
  wire        rxd = loop_en ? txd : raw_rxd;

  int checks = 0;
  int errors = 0;
  int tick_n = 0;
  int div = 0;
  int rv_cnt = 0;
  int cap_tick = 0;
  logic [7:0] cap_data = '0;
  logic cap_fe = 1'b0, cap_pe = 1'b0, cap_brk = 1'b0;

  async_char_framer u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .tick16_i(tick),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .txd_o(txd), .rxd_i(rxd), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_frame_err_o(fe), .rx_parity_err_o(pe), .rx_break_o(brk)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tick = (div == 2);
    div  = (div == 2) ? 0 : div + 1;
  end

  always @(posedge clk) if (tick) tick_n <= tick_n + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_data = rx_data;
      cap_fe   = fe;
      cap_pe   = pe;
      cap_brk  = brk;
      cap_tick = tick_n;
      rv_cnt++;
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic wait_tick(input int target);
    while (tick_n < target) @(negedge clk);
  endtask

  task automatic raw_bits(input logic v, input int n);
    int t;
    raw_rxd = v;
    t = tick_n;
    wait_tick(t + n);
  endtask

  task automatic raw_frame(input logic [4:0] f, input logic [7:0] d, input logic pbit,
                           input logic s1, input logic s2, input int s2_ticks);
    int len;
    len = 5 + int'(f[1:0]);
    fmt = f;
    loop_en = 1'b0;
    raw_bits(1'b0, 16);
    for (int i = 0; i < len; i++) raw_bits(d[i], 16);
    if (f[3]) raw_bits(pbit, 16);
    raw_bits(s1, 16);
    if (s2_ticks > 0) raw_bits(s2, s2_ticks);
    raw_rxd = 1'b1;
  endtask

  task automatic tx_frame(input logic [4:0] f, input logic [7:0] d);
    int len, pn, sl, fl, t0, base, lat;
    logic [7:0] m;
    logic ep;
    fmt = f;
    loop_en = 1'b1;
    len = 5 + int'(f[1:0]);
    pn  = int'(f[3]);
    sl  = !f[2] ? 16 : ((f[1:0] == 2'b00) ? 24 : 32);
    fl  = 16 * (1 + len + pn) + sl;
    m   = 8'hFF >> (8 - len);
    ep  = f[4] ? (^(d & m)) : ~(^(d & m));
    base = rv_cnt;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
    t0 = tick_n;
    chk(!tx_ready, "R5 ready low after accept", tx_ready, 0);
    chk(!txd, "R5 start bit begins next cycle", txd, 0);
    wait_tick(t0 + 8);
    chk(txd == 1'b0, "R1 start bit mid", txd, 0);
    for (int i = 0; i < len; i++) begin
      wait_tick(t0 + 16 * (i + 1) + 8);
      chk(txd == d[i], $sformatf("R1 data bit %0d len %0d", i, len), txd, d[i]);
    end
    if (pn != 0) begin
      wait_tick(t0 + 16 * (1 + len) + 8);
      chk(txd == ep, $sformatf("R4 parity fmt %0h", f), txd, ep);
    end
    wait_tick(t0 + 16 * (1 + len + pn) + 8);
    chk(txd == 1'b1, "R2 first stop high", txd, 1);
    if (sl > 16) begin
      wait_tick(t0 + 16 * (1 + len + pn) + sl - 4);
      chk(txd == 1'b1, "R3 long stop high", txd, 1);
    end
    wait_tick(t0 + fl - 1);
    chk(!tx_ready, (sl == 16) ? "R2 stop not yet over" : "R3 stop not yet over", tx_ready, 0);
    wait_tick(t0 + fl);
    chk(tx_ready, (sl == 16) ? "R2 ready at stop end" : "R3 ready at stop end", tx_ready, 1);
    chk(rv_cnt == base + 1, "R7 one result per character", rv_cnt - base, 1);
    chk(cap_data == (d & m), $sformatf("R7 rx data fmt %0h", f), cap_data, d & m);
    chk(!cap_fe, "R9 no framing error", cap_fe, 0);
    chk(!cap_brk, "R10 no break", cap_brk, 0);
    chk(!cap_pe, "R11 parity matches", cap_pe, 0);
    lat = cap_tick - t0 - 16 * (1 + len + pn);
    chk(lat >= 8 && lat <= 11, "R7 result timing in first stop", lat, 9);
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk(tx_ready && txd && !rx_valid, "R12 reset state", {tx_ready, txd, rx_valid}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready && txd && !rx_valid, "R12 after reset", {tx_ready, txd, rx_valid}, 3'b110);

    // R6: short low pulse
    base = rv_cnt;
    raw_bits(1'b0, 5);
    raw_bits(1'b1, 16 * 12);
    chk(rv_cnt == base, "R6 glitch ignored", rv_cnt - base, 0);

    // R8: second stop low
    base = rv_cnt;
    raw_frame(5'b00111, 8'h5A, 1'b0, 1'b1, 1'b0, 16);
    chk(rv_cnt == base + 1, "R8 character delivered", rv_cnt - base, 1);
    chk(!cap_fe, "R8 second stop ignored", cap_fe, 0);
    chk(cap_data == 8'h5A, "R8 data", cap_data, 8'h5A);
    raw_bits(1'b1, 16 * 14);

    // R9: first stop low
    base = rv_cnt;
    raw_frame(5'b00011, 8'hC3, 1'b0, 1'b0, 1'b1, 0);
    chk(rv_cnt == base + 1, "R9 character delivered", rv_cnt - base, 1);
    chk(cap_fe, "R9 framing error", cap_fe, 1);
    chk(!cap_brk, "R10 not a break", cap_brk, 0);
    chk(cap_data == 8'hC3, "R9 data", cap_data, 8'hC3);
    raw_bits(1'b1, 16 * 14);

    // R10: break with parity bit low too
    base = rv_cnt;
    raw_frame(5'b11010, 8'h00, 1'b0, 1'b0, 1'b0, 16);
    chk(rv_cnt == base + 1, "R10 character delivered", rv_cnt - base, 1);
    chk(cap_brk, "R10 break flagged", cap_brk, 1);
    chk(cap_fe, "R10 break with framing error", cap_fe, 1);
    chk(cap_data == 8'h00, "R10 data zero", cap_data, 0);
    raw_bits(1'b1, 16 * 14);

    // R11: wrong parity, 5-bit even
    base = rv_cnt;
    raw_frame(5'b11000, 8'h16, 1'b0, 1'b1, 1'b1, 0);
    chk(rv_cnt == base + 1, "R11 character delivered", rv_cnt - base, 1);
    chk(cap_pe, "R11 parity error", cap_pe, 1);
    chk(!cap_fe, "R11 no framing error", cap_fe, 0);
    chk(cap_data == 8'h16, "R11 data", cap_data, 8'h16);
    raw_bits(1'b1, 16 * 14);

    // sweep every format with looped-back line
    for (int f = 0; f < 32; f++) begin
      for (int j = 0; j < 3; j++) begin
        tx_frame(5'(f), (j == 0) ? 8'hA5 : ((j == 1) ? 8'h00 : 8'hFF));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule